// File: doc/BRIEF.md
# Raster NMI and Timer IRQ Controller

This block produces the two raster interrupts that a CPU needs when it works next to a video unit. The first is a vertical-blank non-maskable interrupt, raised once the line counter passes the last visible line. The second is a timer interrupt, raised when the beam reaches a programmed dot, a programmed line, or both. The block watches the live dot and line counters from the video unit. It keeps a short history of both counters, so each condition is tested against counter values from a fixed number of clocks earlier. This models the delay between the video unit and the interrupt logic.

The conditions are tested once per poll period of `POLL_DIV` clocks. Each interrupt has four pieces of state:
- a level flag;
- a one-period hold that stops a status read from clearing the flag in the same period in which it was set;
- a pending edge that drives the request output;
- its enable bits.

A write to the enable register has side effects on the pending edges. A status read returns a flag and clears it. An acknowledge test consumes a pending edge and releases the CPU wait state.

Top module: `raster_irq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it is released, the design holds every flag, hold, pending edge and enable at zero. Both request outputs are 0, and status reads return 0.
- R2: The first poll takes place on the fourth rising edge after reset is released, and every fourth edge after that. At a poll, the NMI flag takes the new value of the condition "line counter delayed by 2 clocks >= `last_line`" whenever that condition changes. Between polls, only a status read can change the NMI flag.
- R3: When a poll sets the NMI flag, it also sets an NMI hold that lasts until the next poll. An NMI status read (`nmi_rd`) returns the flag on `nmi_rd_data`. The read clears the flag only when the hold is not set.
- R4: At a poll that ends an NMI hold, if NMI is enabled (enable bit 7), the design latches a pending NMI edge, which is shown on `nmi_req`. If NMI is disabled, no edge is latched.
- R5: A write to the enable register that changes bit 7 from 0 to 1 while the NMI flag is set latches a pending NMI edge.
- R6: An NMI acknowledge (`nmi_ack`) drives `nmi_ack_hit` and `wait_release` high only when an NMI edge is pending, and it clears that edge.
- R7: The timer condition is true when at least one of enable bit 4 (dot match) and enable bit 5 (line match) is set, and every enabled match holds. The dot match compares the dot counter delayed by 10 clocks with `h_cmp`. The line match compares the line counter delayed by 10 clocks with `v_cmp`.
- R8: The timer condition is forced false when the dot counter and the line counter, both delayed by 6 clocks, are zero.
- R9: A rising edge of the timer condition at a poll sets the IRQ flag and an IRQ hold. Every poll clears the hold first. At each poll where the IRQ flag and the IRQ enable are both set, the design latches a pending IRQ edge, which is shown on `irq_req`.
- R10: A timer status read (`tmr_rd`) returns the IRQ flag on `tmr_rd_data`. Unless the IRQ hold is set, the read clears both the flag and the pending IRQ edge.
- R11: A write to the enable register with bit 5 set, bit 4 clear and the IRQ flag set latches a pending IRQ edge. A write with bits 4 and 5 both clear clears the IRQ flag and the pending IRQ edge.
- R12: An IRQ acknowledge (`irq_ack`) takes effect when an IRQ edge is pending or `irq_ext` is high. It then clears the pending edge and drives `wait_release` high. It drives `irq_ack_hit` high only if `cpu_idis` is 0.
- R13: Within one clock, the design applies status reads and acknowledges to the registered state first, then the enable write, then the poll. Read and acknowledge outputs reflect the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_cnt | input | H_W | Live horizontal dot counter |
| line_cnt | input | V_W | Live vertical line counter |
| last_line | input | V_W | Number of the last visible line |
| h_cmp | input | H_W | Dot compare value for the timer |
| v_cmp | input | V_W | Line compare value for the timer |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable write data: bit 4 dot match, bit 5 line match, bit 7 NMI |
| nmi_rd | input | 1 | NMI status read strobe |
| nmi_rd_data | output | 1 | NMI flag returned while `nmi_rd` is high |
| tmr_rd | input | 1 | Timer status read strobe |
| tmr_rd_data | output | 1 | IRQ flag returned while `tmr_rd` is high |
| nmi_ack | input | 1 | NMI acknowledge test strobe |
| nmi_ack_hit | output | 1 | NMI test result |
| irq_ack | input | 1 | IRQ acknowledge test strobe |
| irq_ext | input | 1 | External IRQ level |
| cpu_idis | input | 1 | CPU interrupt-disable flag |
| irq_ack_hit | output | 1 | IRQ test result |
| wait_release | output | 1 | Releases the CPU wait state |
| nmi_req | output | 1 | Pending NMI edge |
| irq_req | output | 1 | Pending IRQ edge |

## Verification
The assertions assume that reset is high from time zero. They also assume that every strobe input is a plain synchronous level and that the counters are free to take any value. They do not assume that strobes are exclusive, because R13 fixes the order in which same-cycle events are applied. The stimulus changes inputs only on falling edges, and it keeps the counters constant for at least ten clocks before it waits on a poll result. It counts rising edges from reset release to place each strobe at a known offset from a poll. In particular, it places the hold-window reads in the period that starts with the poll that set the flag.

// File: rtl/rirq_pkg.sv
`timescale 1ns/1ps
package rirq_pkg;

    // Positions of the enable register bits.
    localparam int EN_DOT_BIT  = 4;
    localparam int EN_LINE_BIT = 5;
    localparam int EN_NMI_BIT  = 7;

    typedef struct packed {
        logic valid;   // last polled vblank condition
        logic flag;    // status flag
        logic hold;    // read-protect for one poll period
        logic pend;    // pending edge toward the CPU
        logic en;      // NMI enable
    } nmi_st_t;

    typedef struct packed {
        logic valid;   // last polled timer condition
        logic flag;    // status flag
        logic hold;    // read-protect for one poll period
        logic pend;    // pending edge toward the CPU
        logic dot_en;  // dot match enable
        logic line_en; // line match enable
    } irq_st_t;

endpackage

// File: rtl/rirq_poll_timer.sv
`timescale 1ns/1ps
module rirq_poll_timer #(
    parameter int POLL_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic poll_o
);
    localparam int PW = (POLL_DIV > 2) ? $clog2(POLL_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(POLL_DIV - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    assign poll_o = (phase_q == LAST);
endmodule

// File: rtl/rirq_cnt_history.sv
`timescale 1ns/1ps
module rirq_cnt_history #(
    parameter int H_W      = 9,
    parameter int V_W      = 9,
    parameter int NMI_DLY  = 2,
    parameter int EDGE_DLY = 6,
    parameter int IRQ_DLY  = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [H_W-1:0] dot_i,
    input  logic [V_W-1:0] line_i,
    output logic [V_W-1:0] line_nmi_o,
    output logic [H_W-1:0] dot_edge_o,
    output logic [V_W-1:0] line_edge_o,
    output logic [H_W-1:0] dot_irq_o,
    output logic [V_W-1:0] line_irq_o
);
    localparam int MAX_A = (NMI_DLY > EDGE_DLY) ? NMI_DLY : EDGE_DLY;
    localparam int DEPTH = (MAX_A > IRQ_DLY) ? MAX_A : IRQ_DLY;

    logic [H_W-1:0] dot_d  [DEPTH];
    logic [H_W-1:0] dot_q  [DEPTH];
    logic [V_W-1:0] line_d [DEPTH];
    logic [V_W-1:0] line_q [DEPTH];

    // Stage k holds the counter value from k+1 clocks earlier.
    always_comb begin
        dot_d[0]  = dot_i;
        line_d[0] = line_i;
        for (int i = 1; i < DEPTH; i++) begin
            dot_d[i]  = dot_q[i-1];
            line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                dot_q[i]  <= '0;
                line_q[i] <= '0;
            end
        end else begin
            dot_q  <= dot_d;
            line_q <= line_d;
        end
    end

    generate
        if (NMI_DLY > 0) begin : g_nmi_tap
            assign line_nmi_o = line_q[NMI_DLY-1];
        end else begin : g_nmi_live
            assign line_nmi_o = line_i;
        end
        if (EDGE_DLY > 0) begin : g_edge_tap
            assign dot_edge_o  = dot_q[EDGE_DLY-1];
            assign line_edge_o = line_q[EDGE_DLY-1];
        end else begin : g_edge_live
            assign dot_edge_o  = dot_i;
            assign line_edge_o = line_i;
        end
        if (IRQ_DLY > 0) begin : g_irq_tap
            assign dot_irq_o  = dot_q[IRQ_DLY-1];
            assign line_irq_o = line_q[IRQ_DLY-1];
        end else begin : g_irq_live
            assign dot_irq_o  = dot_i;
            assign line_irq_o = line_i;
        end
    endgenerate
endmodule

// File: rtl/rirq_nmi_unit.sv
`timescale 1ns/1ps
module rirq_nmi_unit
    import rirq_pkg::*;
#(
    parameter int V_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           poll,
    input  logic [V_W-1:0] line_dly,
    input  logic [V_W-1:0] last_line,
    input  logic           wr,
    input  logic           wr_en,
    input  logic           rd,
    input  logic           ack,
    output logic           flag_o,
    output logic           hold_o,
    output logic           pend_o,
    output logic           rd_val,
    output logic           ack_hit
);
    nmi_st_t st_d, st_q;
    logic    vblank_now;

    always_comb begin
        st_d       = st_q;
        vblank_now = (line_dly >= last_line);
        rd_val     = rd & st_q.flag;
        ack_hit    = ack & st_q.pend;

        // reads and acknowledges act on the registered state
        if (rd && !st_q.hold) st_d.flag = 1'b0;
        if (ack)              st_d.pend = 1'b0;

        // enable write
        if (wr) begin
            if (wr_en && !st_q.en && st_d.flag) st_d.pend = 1'b1;
            st_d.en = wr_en;
        end

        // poll
        if (poll) begin
            if (st_d.hold && st_d.en) st_d.pend = 1'b1;
            st_d.hold = 1'b0;
            if (vblank_now != st_d.valid) begin
                st_d.valid = vblank_now;
                st_d.flag  = vblank_now;
                if (vblank_now) st_d.hold = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign hold_o = st_q.hold;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/rirq_irq_unit.sv
`timescale 1ns/1ps
module rirq_irq_unit
    import rirq_pkg::*;
#(
    parameter int H_W = 9,
    parameter int V_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           poll,
    input  logic [H_W-1:0] dot_irq,
    input  logic [V_W-1:0] line_irq,
    input  logic [H_W-1:0] dot_edge,
    input  logic [V_W-1:0] line_edge,
    input  logic [H_W-1:0] h_cmp,
    input  logic [V_W-1:0] v_cmp,
    input  logic           wr,
    input  logic           wr_dot,
    input  logic           wr_line,
    input  logic           rd,
    input  logic           ack,
    input  logic           ext,
    input  logic           idis,
    output logic           flag_o,
    output logic           hold_o,
    output logic           pend_o,
    output logic           rd_val,
    output logic           ack_take,
    output logic           ack_hit
);
    irq_st_t st_d, st_q;
    logic    any_en, dot_ok, line_ok, not_field_end, cond;

    always_comb begin
        st_d     = st_q;
        rd_val   = rd & st_q.flag;
        ack_take = ack & (st_q.pend | ext);
        ack_hit  = ack_take & ~idis;

        // reads and acknowledges
        if (rd && !st_q.hold) begin
            st_d.flag = 1'b0;
            st_d.pend = 1'b0;
        end
        if (ack_take) st_d.pend = 1'b0;

        // enable write
        if (wr) begin
            st_d.dot_en  = wr_dot;
            st_d.line_en = wr_line;
            if (wr_line && !wr_dot && st_d.flag) begin
                st_d.pend = 1'b1;
            end else if (!wr_line && !wr_dot) begin
                st_d.flag = 1'b0;
                st_d.pend = 1'b0;
            end
        end

        // poll
        any_en        = st_d.dot_en | st_d.line_en;
        dot_ok        = !st_d.dot_en  || (dot_irq  == h_cmp);
        line_ok       = !st_d.line_en || (line_irq == v_cmp);
        not_field_end = (dot_edge != '0) || (line_edge != '0);
        cond          = any_en && dot_ok && line_ok && not_field_end;
        if (poll) begin
            st_d.hold = 1'b0;
            if (st_d.flag && any_en) st_d.pend = 1'b1;
            if (cond && !st_d.valid) begin
                st_d.flag = 1'b1;
                st_d.hold = 1'b1;
            end
            st_d.valid = cond;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign hold_o = st_q.hold;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/raster_irq_ctrl.sv
`timescale 1ns/1ps
module raster_irq_ctrl
    import rirq_pkg::*;
#(
    parameter int H_W      = 9,
    parameter int V_W      = 9,
    parameter int POLL_DIV = 4,
    parameter int NMI_DLY  = 2,
    parameter int EDGE_DLY = 6,
    parameter int IRQ_DLY  = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [H_W-1:0] dot_cnt,
    input  logic [V_W-1:0] line_cnt,
    input  logic [V_W-1:0] last_line,
    input  logic [H_W-1:0] h_cmp,
    input  logic [V_W-1:0] v_cmp,
    input  logic           en_wr,
    input  logic [7:0]     en_wdata,
    input  logic           nmi_rd,
    output logic           nmi_rd_data,
    input  logic           tmr_rd,
    output logic           tmr_rd_data,
    input  logic           nmi_ack,
    output logic           nmi_ack_hit,
    input  logic           irq_ack,
    input  logic           irq_ext,
    input  logic           cpu_idis,
    output logic           irq_ack_hit,
    output logic           wait_release,
    output logic           nmi_req,
    output logic           irq_req
);
    logic           poll;
    logic [V_W-1:0] line_nmi;
    logic [H_W-1:0] dot_edge;
    logic [V_W-1:0] line_edge;
    logic [H_W-1:0] dot_irq;
    logic [V_W-1:0] line_irq;
    logic           wr_dot, wr_line, wr_nmi;
    logic           nmi_flag, nmi_hold, irq_flag, irq_hold;
    logic           irq_take;
    logic           unused_wbits;

    assign wr_dot       = en_wdata[EN_DOT_BIT];
    assign wr_line      = en_wdata[EN_LINE_BIT];
    assign wr_nmi       = en_wdata[EN_NMI_BIT];
    assign unused_wbits = ^{en_wdata[6], en_wdata[3:0], irq_hold};

    rirq_poll_timer #(.POLL_DIV(POLL_DIV)) u_poll (
        .clk(clk), .rst(rst), .poll_o(poll)
    );

    rirq_cnt_history #(
        .H_W(H_W), .V_W(V_W),
        .NMI_DLY(NMI_DLY), .EDGE_DLY(EDGE_DLY), .IRQ_DLY(IRQ_DLY)
    ) u_hist (
        .clk(clk), .rst(rst),
        .dot_i(dot_cnt), .line_i(line_cnt),
        .line_nmi_o(line_nmi),
        .dot_edge_o(dot_edge), .line_edge_o(line_edge),
        .dot_irq_o(dot_irq), .line_irq_o(line_irq)
    );

    rirq_nmi_unit #(.V_W(V_W)) u_nmi (
        .clk(clk), .rst(rst), .poll(poll),
        .line_dly(line_nmi), .last_line(last_line),
        .wr(en_wr), .wr_en(wr_nmi),
        .rd(nmi_rd), .ack(nmi_ack),
        .flag_o(nmi_flag), .hold_o(nmi_hold), .pend_o(nmi_req),
        .rd_val(nmi_rd_data), .ack_hit(nmi_ack_hit)
    );

    rirq_irq_unit #(.H_W(H_W), .V_W(V_W)) u_irq (
        .clk(clk), .rst(rst), .poll(poll),
        .dot_irq(dot_irq), .line_irq(line_irq),
        .dot_edge(dot_edge), .line_edge(line_edge),
        .h_cmp(h_cmp), .v_cmp(v_cmp),
        .wr(en_wr), .wr_dot(wr_dot), .wr_line(wr_line),
        .rd(tmr_rd), .ack(irq_ack), .ext(irq_ext), .idis(cpu_idis),
        .flag_o(irq_flag), .hold_o(irq_hold), .pend_o(irq_req),
        .rd_val(tmr_rd_data), .ack_take(irq_take), .ack_hit(irq_ack_hit)
    );

    assign wait_release = nmi_ack_hit | irq_take;
endmodule

// File: rtl/rirq_checker.sv
`timescale 1ns/1ps
module rirq_checker #(
    parameter int H_W = 9,
    parameter int V_W = 9
) (
    input logic           clk,
    input logic           rst,
    input logic           poll,
    input logic           en_wr,
    input logic           wr_dot,
    input logic           wr_line,
    input logic           nmi_rd,
    input logic           nmi_ack,
    input logic           irq_ack,
    input logic           irq_ext,
    input logic           cpu_idis,
    input logic           nmi_req,
    input logic           irq_req,
    input logic           nmi_ack_hit,
    input logic           irq_ack_hit,
    input logic           wait_release,
    input logic           nmi_flag,
    input logic           nmi_hold,
    input logic           irq_flag,
    input logic [H_W-1:0] dot_edge,
    input logic [V_W-1:0] line_edge
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!nmi_req && !irq_req && !nmi_flag && !irq_flag));

    p_nmi_flag_moves_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(nmi_flag) |-> ($past(poll) || $past(nmi_rd)));

    p_nmi_hold_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (nmi_rd && nmi_hold && nmi_flag && !poll) |=> nmi_flag);

    p_nmi_edge_src_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |-> ($past(poll) || $past(en_wr)));

    p_nmi_ack_r6: assert property (@(posedge clk) disable iff (rst)
        nmi_ack_hit |-> (nmi_req && wait_release));

    p_release_src_r6: assert property (@(posedge clk) disable iff (rst)
        wait_release |-> (nmi_ack || irq_ack));

    p_field_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> ($past(poll) && ($past(dot_edge) != '0 || $past(line_edge) != '0)));

    p_irq_edge_src_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> ($past(poll) || $past(en_wr)));

    p_irq_off_r11: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !wr_dot && !wr_line) |=> (!irq_flag && !irq_req));

    p_irq_hit_r12: assert property (@(posedge clk) disable iff (rst)
        irq_ack_hit |-> ((irq_req || irq_ext) && !cpu_idis && wait_release));
endmodule

bind raster_irq_ctrl rirq_checker #(.H_W(H_W), .V_W(V_W)) u_chk (
    .clk(clk), .rst(rst), .poll(poll), .en_wr(en_wr),
    .wr_dot(wr_dot), .wr_line(wr_line), .nmi_rd(nmi_rd),
    .nmi_ack(nmi_ack), .irq_ack(irq_ack), .irq_ext(irq_ext),
    .cpu_idis(cpu_idis), .nmi_req(nmi_req), .irq_req(irq_req),
    .nmi_ack_hit(nmi_ack_hit), .irq_ack_hit(irq_ack_hit),
    .wait_release(wait_release), .nmi_flag(nmi_flag),
    .nmi_hold(nmi_hold), .irq_flag(irq_flag),
    .dot_edge(dot_edge), .line_edge(line_edge)
);

// File: tb/raster_irq_ctrl_test.sv
`timescale 1ns/1ps
module raster_irq_ctrl_test;
    localparam int H_W = 9;
    localparam int V_W = 9;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [H_W-1:0] dot_cnt = '0;
    logic [V_W-1:0] line_cnt = '0;
    logic [V_W-1:0] last_line = 9'd100;
    logic [H_W-1:0] h_cmp = '0;
    logic [V_W-1:0] v_cmp = '0;
    logic           en_wr = 1'b0;
    logic [7:0]     en_wdata = '0;
    logic           nmi_rd = 1'b0, tmr_rd = 1'b0;
    logic           nmi_ack = 1'b0, irq_ack = 1'b0;
    logic           irq_ext = 1'b0, cpu_idis = 1'b0;
    logic           nmi_rd_data, tmr_rd_data, nmi_ack_hit, irq_ack_hit;
    logic           wait_release, nmi_req, irq_req;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;

    raster_irq_ctrl uut (
        .clk(clk), .rst(rst), .dot_cnt(dot_cnt), .line_cnt(line_cnt),
        .last_line(last_line), .h_cmp(h_cmp), .v_cmp(v_cmp),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .nmi_rd(nmi_rd), .nmi_rd_data(nmi_rd_data),
        .tmr_rd(tmr_rd), .tmr_rd_data(tmr_rd_data),
        .nmi_ack(nmi_ack), .nmi_ack_hit(nmi_ack_hit),
        .irq_ack(irq_ack), .irq_ext(irq_ext), .cpu_idis(cpu_idis),
        .irq_ack_hit(irq_ack_hit), .wait_release(wait_release),
        .nmi_req(nmi_req), .irq_req(irq_req)
    );

    always #10 clk = ~clk;

    // rising edges since reset release; a poll lands on multiples of 4 (R2)
    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dot_cnt = '0; line_cnt = '0; last_line = 9'd100;
        h_cmp = '0; v_cmp = '0; irq_ext = 1'b0; cpu_idis = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic to_post_poll();
        do @(negedge clk); while (ecnt % 4 != 0);
    endtask

    task automatic wait_polls(input int n);
        for (int i = 0; i < n; i++) to_post_poll();
    endtask

    task automatic write_en(input logic [7:0] v);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic read_nmi(output logic v);
        nmi_rd = 1'b1; #1 v = nmi_rd_data;
        @(negedge clk);
        nmi_rd = 1'b0;
    endtask

    task automatic read_tmr(output logic v);
        tmr_rd = 1'b1; #1 v = tmr_rd_data;
        @(negedge clk);
        tmr_rd = 1'b0;
    endtask

    task automatic ack_nmi(output logic hit, output logic rel);
        nmi_ack = 1'b1; #1 hit = nmi_ack_hit; rel = wait_release;
        @(negedge clk);
        nmi_ack = 1'b0;
    endtask

    task automatic ack_irq(output logic hit, output logic rel);
        irq_ack = 1'b1; #1 hit = irq_ack_hit; rel = wait_release;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic v;
        do_reset();
        check("R1 nmi_req", nmi_req, 1'b0);
        check("R1 irq_req", irq_req, 1'b0);
        read_nmi(v); check("R1 nmi read", v, 1'b0);
        read_tmr(v); check("R1 timer read", v, 1'b0);
    endtask

    task automatic t_nmi_flag();
        logic v;
        do_reset();
        to_post_poll();
        line_cnt = 9'd150;
        wait_polls(2);
        read_nmi(v); check("R2 flag set", v, 1'b1);
        read_nmi(v); check("R2 flag cleared by read", v, 1'b0);
        line_cnt = 9'd20;  wait_polls(2);
        line_cnt = 9'd100; wait_polls(2);
        line_cnt = 9'd30;  wait_polls(2);
        read_nmi(v); check("R2 flag falls with condition", v, 1'b0);
    endtask

    task automatic t_nmi_hold();
        logic v;
        do_reset();
        to_post_poll();
        line_cnt = 9'd150;   // visible at the next poll
        to_post_poll();
        read_nmi(v); check("R3 read in hold returns 1", v, 1'b1);
        read_nmi(v); check("R3 hold keeps flag", v, 1'b1);
        to_post_poll();
        check("R4 no edge when NMI disabled", nmi_req, 1'b0);
        read_nmi(v); check("R3 read after hold returns 1", v, 1'b1);
        read_nmi(v); check("R3 read after hold cleared", v, 1'b0);
    endtask

    task automatic t_nmi_edge();
        logic hit, rel;
        do_reset();
        to_post_poll();
        write_en(8'h80);
        line_cnt = 9'd200;
        wait_polls(3);
        check("R4 edge at hold end", nmi_req, 1'b1);
        ack_nmi(hit, rel);
        check("R6 hit", hit, 1'b1);
        check("R6 release", rel, 1'b1);
        check("R6 edge consumed", nmi_req, 1'b0);
        ack_nmi(hit, rel);
        check("R6 no hit without edge", hit, 1'b0);
        check("R6 no release without edge", rel, 1'b0);
    endtask

    task automatic t_nmi_enable_write();
        do_reset();
        to_post_poll();
        line_cnt = 9'd180;
        wait_polls(3);
        check("R5 nothing pending while disabled", nmi_req, 1'b0);
        to_post_poll();
        write_en(8'h80);
        check("R5 enable rise latches edge", nmi_req, 1'b1);
    endtask

    task automatic t_irq_line();
        logic v;
        do_reset();
        line_cnt = 9'd5; dot_cnt = 9'd7; v_cmp = 9'd5; h_cmp = 9'd99;
        wait_polls(3);
        to_post_poll();
        write_en(8'h20);      // condition rises at the next poll
        to_post_poll();
        read_tmr(v); check("R10 read in hold returns 1", v, 1'b1);
        to_post_poll();
        check("R9 edge latched, R10 hold kept flag", irq_req, 1'b1);
        read_tmr(v); check("R7 line match flag", v, 1'b1);
        check("R10 read clears edge", irq_req, 1'b0);
        read_tmr(v); check("R10 read cleared flag", v, 1'b0);
    endtask

    task automatic t_irq_dot();
        do_reset();
        line_cnt = 9'd3; dot_cnt = 9'd8; h_cmp = 9'd9; v_cmp = 9'd40;
        to_post_poll();
        write_en(8'h10);
        wait_polls(5);
        check("R7 dot mismatch no irq", irq_req, 1'b0);
        dot_cnt = 9'd9;
        wait_polls(5);
        check("R7 dot match irq", irq_req, 1'b1);
        do_reset();
        line_cnt = 9'd3; dot_cnt = 9'd9; h_cmp = 9'd9; v_cmp = 9'd40;
        to_post_poll();
        write_en(8'h30);
        wait_polls(5);
        check("R7 both enabled, line mismatch", irq_req, 1'b0);
        line_cnt = 9'd40;
        wait_polls(5);
        check("R7 both enabled and matching", irq_req, 1'b1);
    endtask

    task automatic t_field_end();
        logic v;
        do_reset();
        line_cnt = '0; dot_cnt = '0; v_cmp = '0;
        to_post_poll();
        write_en(8'h20);
        wait_polls(5);
        check("R8 no irq on field end", irq_req, 1'b0);
        read_tmr(v); check("R8 flag stays clear", v, 1'b0);
        dot_cnt = 9'd1;
        wait_polls(5);
        check("R8 irq once dot nonzero", irq_req, 1'b1);
    endtask

    task automatic t_irq_write();
        logic hit, rel, v;
        do_reset();
        line_cnt = 9'd3; dot_cnt = 9'd9; h_cmp = 9'd9;
        to_post_poll();
        write_en(8'h10);
        wait_polls(5);
        check("R9 edge pending", irq_req, 1'b1);
        to_post_poll();
        ack_irq(hit, rel);
        check("R12 ack consumes edge", irq_req, 1'b0);
        write_en(8'h20);
        check("R11 line-only write relatches", irq_req, 1'b1);
        write_en(8'h00);
        check("R11 disable clears edge", irq_req, 1'b0);
        read_tmr(v); check("R11 disable clears flag", v, 1'b0);
    endtask

    task automatic t_irq_ack();
        logic hit, rel;
        do_reset();
        to_post_poll();
        irq_ext = 1'b1; cpu_idis = 1'b0;
        ack_irq(hit, rel);
        check("R12 ext level hit", hit, 1'b1);
        check("R12 ext level release", rel, 1'b1);
        cpu_idis = 1'b1;
        ack_irq(hit, rel);
        check("R12 masked no hit", hit, 1'b0);
        check("R12 masked still releases", rel, 1'b1);
        irq_ext = 1'b0; cpu_idis = 1'b0;
        ack_irq(hit, rel);
        check("R12 idle no hit", hit, 1'b0);
        check("R12 idle no release", rel, 1'b0);
    endtask

    // R13: a same-cycle read returns the state held before that edge
    task automatic t_order();
        logic v;
        do_reset();
        to_post_poll();
        line_cnt = 9'd150;
        do @(negedge clk); while (ecnt % 4 != 3);
        read_nmi(v);   // shares its edge with the poll that sets the flag
        check("R13 read sees state before poll", v, 1'b0);
        read_nmi(v);
        check("R13 poll applied after read", v, 1'b1);
    endtask

    initial begin
        t_reset();
        t_nmi_flag();
        t_nmi_hold();
        t_nmi_edge();
        t_nmi_enable_write();
        t_irq_line();
        t_irq_dot();
        t_field_end();
        t_irq_write();
        t_irq_ack();
        t_order();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule